// File: doc/BRIEF.md
# JTAG User Register Bridge

This block sits on the host side of a user-defined JTAG data register and gives a host access to a small register file. The register file holds eight state words, three message words and a clock setting. It also holds a queue of results that a compute core pushes. The host drives a simplified TAP-side port made of three strobes (capture, shift, update) plus serial `tdi` and `tdo`. All of these are sampled on the block's own clock.

A write scan has 38 bits and carries data, an address, a write flag and a parity bit. A read request has 6 bits and carries an address, a zero flag and a parity bit. The data-register scan that follows a read request shifts out the 32-bit value of the selected register. Reading the result address removes the oldest queue entry. When the queue is empty, that read returns all ones. A scan with the wrong length, the wrong flag or bad parity leaves every piece of state as it was.

Top module: `jtag_regbridge`

## Requirements
- R1: A write scan has 38 bits, shifted in bit 0 first. Bits 0–31 are data, LSB first. Bits 32–35 are the address. Bit 36 is the write flag and must be 1. Bit 37 is parity. At update, a valid write stores the data in the addressed register.
- R2: A read request has 6 bits. Bits 0–3 are the address, bit 4 must be 0 and bit 5 is parity. At the capture of the next data-register scan, `tdo` shows bit 0 of the selected 32-bit value. Each shift then presents the next bit, LSB first.
- R3: The parity bit must make the count of ones in the whole scan, parity included, odd. A scan with even parity is ignored: no register changes, no queue entry is popped and no read is selected.
- R4: At update, a scan is ignored in each of these cases:
  - its shift count is neither 6 nor 38;
  - it has 38 bits but bit 36 is 0;
  - it has 6 bits but bit 4 is 1.
- R5: Addresses 1–8 hold the state words. Word at address k appears on `state_words[32*(k-1) +: 32]`. Addresses 9–11 hold the message words. Word at address k appears on `msg_words[32*(k-9) +: 32]`.
- R6: Address 13 holds the clock setting in MHz. Its reset value is 200. A write stores the data with bit 0 forced to 0, so the setting is always even. The setting is readable at address 13.
- R7: Reading address 14 captures the oldest queue entry and removes it. `res_pop` is high for exactly that capture cycle. When the queue is empty, the read captures 0xFFFFFFFF and nothing is popped.
- R8: Writes to addresses 0, 12, 14 and 15 are accepted and discarded. Reads of addresses 0, 12 and 15 return 0.
- R9: The queue holds 8 entries, in arrival order. A push while the queue is full is dropped and sets `res_overflow`. Only reset clears `res_overflow`.
- R10: After reset, the following hold:
  - all state and message words are 0;
  - the queue is empty and `res_overflow` is 0;
  - no read is pending, so a data-register scan without a valid read request captures 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dr_capture | input | 1 | Capture strobe of the user data register |
| dr_shift | input | 1 | Shift strobe: one bit per cycle |
| dr_update | input | 1 | Update strobe at the end of a scan |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| res_valid | input | 1 | Push a result into the queue |
| res_word | input | 32 | Result value to push |
| state_words | output | 256 | Eight state words, address 1 in the low word |
| msg_words | output | 96 | Three message words, address 9 in the low word |
| clk_setting | output | 32 | Clock setting in MHz, always even |
| res_pop | output | 1 | One-cycle pulse when a queue entry is removed |
| res_overflow | output | 1 | Sticky flag: a result was dropped |

## Verification
The assertions assume that capture, shift and update are single-cycle strobes that never coincide. They also assume that each scan begins with a capture before any shift. The one-shot check on `res_pop` and the check that a pending read is consumed at capture both depend on this. The bench drives every strobe on the falling clock edge for one cycle at a time and runs each scan strictly as capture, shifts, update. It never pushes a result in the same cycle as a capture.

// File: rtl/jrb_pkg.sv
// Package: shared address map constants for the register bridge.
// Assumes a 4-bit address field; the fixed addresses below fit in it.
package jrb_pkg;
    localparam int ADR_CLK    = 13;  // clock setting register
    localparam int ADR_RESULT = 14;  // result queue read port
endpackage

// File: rtl/jrb_scan_port.sv
// Scan port: a shift register behind the capture/shift/update strobes.
// It counts the shifted bits, checks the length, flag and odd parity at
// update, and issues a write or latches a read selection.
// Assumes the strobes are one-cycle pulses that never coincide.
module jrb_scan_port #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dr_capture,
    input  logic              dr_shift,
    input  logic              dr_update,
    input  logic              tdi,
    input  logic [WORD_W-1:0] cap_word,
    output logic              tdo,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              rd_pending,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int WR_LEN = WORD_W + ADDR_W + 2;
    localparam int RD_LEN = ADDR_W + 2;
    localparam int CNT_W  = $clog2(WR_LEN + 1) + 1;

    logic [WR_LEN-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [RD_LEN-1:0] short_frame;
    logic              wr_ok, rd_ok;

    // Load captured data, or shift in from the top (bit 0 ends lowest).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (dr_capture) begin
            sr_q  <= {{(WR_LEN-WORD_W){1'b0}}, cap_word};
            cnt_q <= '0;
        end else if (dr_shift) begin
            sr_q <= {tdi, sr_q[WR_LEN-1:1]};
            if (cnt_q != '1)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Decode the frame according to its length, flag and parity.
    always_comb begin
        short_frame = sr_q[WR_LEN-1 -: RD_LEN];
        wr_ok = (cnt_q == CNT_W'(WR_LEN)) && sr_q[WR_LEN-2] && (^sr_q);
        rd_ok = (cnt_q == CNT_W'(RD_LEN)) && !short_frame[ADDR_W]
                && (^short_frame);
    end

    assign tdo     = sr_q[0];
    assign wr_en   = dr_update && wr_ok;
    assign wr_addr = sr_q[WORD_W +: ADDR_W];
    assign wr_data = sr_q[WORD_W-1:0];

    // Hold a read selection until the next capture consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pending <= 1'b0;
            rd_addr    <= '0;
        end else if (dr_update && rd_ok) begin
            rd_pending <= 1'b1;
            rd_addr    <= short_frame[ADDR_W-1:0];
        end else if (dr_capture) begin
            rd_pending <= 1'b0;
        end
    end

    assert_read_consumed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_capture && !dr_update) |=> !rd_pending);
    assert_select_needs_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_pending) |-> $past(dr_update));
endmodule

// File: rtl/jrb_regfile.sv
// Register file: state and message words, plus the clock setting.
// Writes to unmapped addresses are dropped; reads of them give zero.
// Assumes N_STATE + N_MSG + 1 is below the clock-setting address.
module jrb_regfile #(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int N_STATE   = 8,
    parameter int N_MSG     = 3,
    parameter int CLK_RESET = 200
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [WORD_W-1:0]         rd_word,
    output logic [N_STATE*WORD_W-1:0] state_words,
    output logic [N_MSG*WORD_W-1:0]   msg_words,
    output logic [WORD_W-1:0]         clk_setting
);
    import jrb_pkg::*;
    localparam int N_WORDS = N_STATE + N_MSG;

    logic [WORD_W-1:0] word_q [N_WORDS];
    logic [WORD_W-1:0] clk_q;

    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_word
        // Store one word when its address (gi+1) is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[gi] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(gi + 1))
                word_q[gi] <= wr_data;
        end
        if (gi < N_STATE) begin : g_state
            assign state_words[gi*WORD_W +: WORD_W] = word_q[gi];
        end else begin : g_msg
            assign msg_words[(gi-N_STATE)*WORD_W +: WORD_W] = word_q[gi];
        end
    end

    // Clock setting; bit 0 is forced low to keep the value even.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_q <= WORD_W'(CLK_RESET);
        else if (wr_en && wr_addr == ADDR_W'(ADR_CLK))
            clk_q <= {wr_data[WORD_W-1:1], 1'b0};
    end

    assign clk_setting = clk_q;

    // Read multiplexer; unmapped addresses give zero.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_WORDS; i++)
            if (rd_addr == ADDR_W'(i + 1))
                rd_word = word_q[i];
        if (rd_addr == ADDR_W'(ADR_CLK))
            rd_word = clk_q;
    end

    assert_clk_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_setting[0] == 1'b0);
    assert_first_word_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(1)) |=> state_words[WORD_W-1:0] == $past(wr_data));
    assert_zero_addr_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> ($stable(state_words) && $stable(msg_words)
                                      && $stable(clk_setting)));
endmodule

// File: rtl/jrb_result_fifo.sv
// Result queue: first in, first out. A push while the queue is full is
// dropped and sets a sticky overflow flag. Assumes pop only when not empty.
module jrb_result_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              full, push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Store an accepted entry.
    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= push_word;
    end

    // Advance the pointers and the count; set overflow on a dropped push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full)
                overflow <= 1'b1;
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/jtag_regbridge.sv
// Top of the bridge: joins the scan port, register file and result queue.
// At capture it selects the word for a pending read and pops the queue
// when the result address is read and an entry is present.
// Assumes single-cycle, non-overlapping capture/shift/update strobes.
module jtag_regbridge #(
    parameter int WORD_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int N_STATE    = 8,
    parameter int N_MSG      = 3,
    parameter int FIFO_DEPTH = 8,
    parameter int CLK_RESET  = 200
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dr_capture,
    input  logic                      dr_shift,
    input  logic                      dr_update,
    input  logic                      tdi,
    output logic                      tdo,
    input  logic                      res_valid,
    input  logic [WORD_W-1:0]         res_word,
    output logic [N_STATE*WORD_W-1:0] state_words,
    output logic [N_MSG*WORD_W-1:0]   msg_words,
    output logic [WORD_W-1:0]         clk_setting,
    output logic                      res_pop,
    output logic                      res_overflow
);
    import jrb_pkg::*;

    logic              wr_en, rd_pending, q_empty;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [WORD_W-1:0] wr_data, rd_word, q_head, cap_word;
    logic              sel_result;

    jrb_scan_port #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) scan_i (
        .clk(clk), .rst_n(rst_n),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .tdi(tdi), .cap_word(cap_word), .tdo(tdo),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_pending(rd_pending), .rd_addr(rd_addr)
    );

    jrb_regfile #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .N_STATE(N_STATE),
                  .N_MSG(N_MSG), .CLK_RESET(CLK_RESET)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_word(rd_word),
        .state_words(state_words), .msg_words(msg_words),
        .clk_setting(clk_setting)
    );

    jrb_result_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(res_valid), .push_word(res_word),
        .pop(res_pop), .head(q_head), .empty(q_empty),
        .overflow(res_overflow)
    );

    // Choose the word loaded at capture and decide whether to pop.
    always_comb begin
        sel_result = (rd_addr == ADDR_W'(ADR_RESULT));
        if (!rd_pending)
            cap_word = '0;
        else if (sel_result)
            cap_word = q_empty ? '1 : q_head;
        else
            cap_word = rd_word;
        res_pop = dr_capture && rd_pending && sel_result && !q_empty;
    end

    assert_pop_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_pop |=> !res_pop);
endmodule

// File: tb/jtag_regbridge_tb_top.sv
module jtag_regbridge_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, tdi = 1'b0;
    logic         tdo;
    logic         res_valid = 1'b0;
    logic [31:0]  res_word = '0;
    logic [255:0] state_words;
    logic [95:0]  msg_words;
    logic [31:0]  clk_setting;
    logic         res_pop, res_overflow;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] got_word;
    event        word_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_regbridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .tdi(tdi), .tdo(tdo), .res_valid(res_valid), .res_word(res_word),
        .state_words(state_words), .msg_words(msg_words),
        .clk_setting(clk_setting), .res_pop(res_pop), .res_overflow(res_overflow)
    );

    // Monitor: pops the expected value for every word read back and compares.
    initial begin
        forever begin
            logic [31:0] e;
            string t;
            @(word_ev);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (got_word !== e) begin
                n_bad++;
                $display("FAIL %s: read got %h expected %h", t, got_word, e);
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", t, got, exp);
        end
    endtask

    // One full scan: capture, n shifts (bit 0 first), update.
    task automatic do_scan(input logic [63:0] bits, input int n,
                           output logic [63:0] outb, output logic popped);
        outb = '0;
        @(negedge clk);
        dr_capture = 1'b1;
        #1 popped = res_pop;
        @(negedge clk);
        dr_capture = 1'b0;
        for (int i = 0; i < n; i++) begin
            outb[i] = tdo;
            tdi = bits[i];
            dr_shift = 1'b1;
            @(negedge clk);
        end
        dr_shift = 1'b0;
        tdi = 1'b0;
        dr_update = 1'b1;
        @(negedge clk);
        dr_update = 1'b0;
    endtask

    task automatic wr_scan(input logic [3:0] a, input logic [31:0] d,
                           input logic flag, input logic bad_par, input int len);
        logic [63:0] b, o;
        logic p;
        b = '0;
        b[31:0] = d;
        b[35:32] = a;
        b[36] = flag;
        b[37] = (~^b[36:0]) ^ bad_par;
        do_scan(b, len, o, p);
    endtask

    task automatic rd_req(input logic [3:0] a, input logic flag, input logic bad_par);
        logic [63:0] b, o;
        logic p;
        b = '0;
        b[3:0] = a;
        b[4] = flag;
        b[5] = (~^b[4:0]) ^ bad_par;
        do_scan(b, 6, o, p);
    endtask

    // Data scan of 32 bits: push the expected word, then hand the result to the monitor.
    task automatic data_scan(input logic [31:0] exp, input string t, output logic popped);
        logic [63:0] o;
        exp_q.push_back(exp);
        tag_q.push_back(t);
        do_scan(64'd0, 32, o, popped);
        got_word = o[31:0];
        ->word_ev;
        @(negedge clk);
    endtask

    task automatic rd_word(input logic [3:0] a, input logic [31:0] exp,
                           input string t, output logic popped);
        rd_req(a, 1'b0, 1'b0);
        data_scan(exp, t, popped);
    endtask

    task automatic push_res(input logic [31:0] v);
        @(negedge clk);
        res_valid = 1'b1;
        res_word = v;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic pp;
        logic [31:0] vals [12];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 clk", clk_setting, 32'd200);
        chk("R10 state0", state_words[31:0], 32'd0);
        chk("R10 msg0", msg_words[31:0], 32'd0);
        chk("R10 ovf", {31'd0, res_overflow}, 32'd0);
        data_scan(32'd0, "R10 no pending read", pp);
        rd_word(4'd14, 32'hFFFF_FFFF, "R7 empty queue", pp);
        chk("R7 no pop when empty", {31'd0, pp}, 32'd0);

        // R1/R5: fill every state and message word
        for (int k = 1; k <= 11; k++) begin
            vals[k] = 32'hA500_0000 ^ (32'h0101_0101 * k);
            wr_scan(4'(k), vals[k], 1'b1, 1'b0, 38);
        end
        for (int k = 1; k <= 8; k++)
            chk("R5 state word", state_words[32*(k-1) +: 32], vals[k]);
        for (int k = 9; k <= 11; k++)
            chk("R5 msg word", msg_words[32*(k-9) +: 32], vals[k]);
        rd_word(4'd3, vals[3], "R2 read state 3", pp);
        rd_word(4'd10, vals[10], "R2 read msg 10", pp);

        // R6: clock setting keeps even values
        wr_scan(4'd13, 32'd251, 1'b1, 1'b0, 38);
        chk("R6 clk even", clk_setting, 32'd250);
        rd_word(4'd13, 32'd250, "R6 read clk", pp);

        // R3: bad parity on write and on read request
        wr_scan(4'd2, 32'h1234_5678, 1'b1, 1'b1, 38);
        chk("R3 bad parity write", state_words[63:32], vals[2]);
        push_res(32'h11);
        push_res(32'h22);
        rd_req(4'd14, 1'b0, 1'b1);
        data_scan(32'd0, "R3 bad parity read", pp);
        chk("R3 no pop", {31'd0, pp}, 32'd0);
        rd_word(4'd14, 32'h11, "R7 oldest first", pp);
        chk("R7 pop pulse", {31'd0, pp}, 32'd1);

        // R4: wrong length, wrong flag
        wr_scan(4'd4, 32'hDEAD_BEEF, 1'b1, 1'b0, 37);
        chk("R4 short write", state_words[127:96], vals[4]);
        wr_scan(4'd4, 32'hDEAD_BEEF, 1'b0, 1'b0, 38);
        chk("R4 flag clear", state_words[127:96], vals[4]);
        rd_req(4'd3, 1'b1, 1'b0);
        data_scan(32'd0, "R4 read flag set", pp);

        // R8: unmapped and read-only addresses
        wr_scan(4'd0, 32'h5555_5555, 1'b1, 1'b0, 38);
        wr_scan(4'd12, 32'h6666_6666, 1'b1, 1'b0, 38);
        wr_scan(4'd15, 32'h7777_7777, 1'b1, 1'b0, 38);
        wr_scan(4'd14, 32'h8888_8888, 1'b1, 1'b0, 38);
        chk("R8 state kept", state_words[31:0], vals[1]);
        chk("R8 clk kept", clk_setting, 32'd250);
        rd_word(4'd0, 32'd0, "R8 read 0", pp);
        rd_word(4'd12, 32'd0, "R8 read 12", pp);
        rd_word(4'd15, 32'd0, "R8 read 15", pp);
        rd_word(4'd14, 32'h22, "R8 queue untouched by write", pp);
        rd_word(4'd14, 32'hFFFF_FFFF, "R7 drained", pp);

        // R9: overflow past eight entries
        for (int i = 0; i < 9; i++)
            push_res(32'd100 + 32'(i));
        chk("R9 overflow set", {31'd0, res_overflow}, 32'd1);
        for (int i = 0; i < 8; i++)
            rd_word(4'd14, 32'd100 + 32'(i), "R9 order", pp);
        rd_word(4'd14, 32'hFFFF_FFFF, "R9 ninth dropped", pp);
        chk("R9 overflow sticky", {31'd0, res_overflow}, 32'd1);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule